// File: doc/BRIEF.md
# Macro Sequencer with Delay Slots

This block runs short macro programs held in a local instruction memory, one 32-bit instruction per clock. Each instruction reads up to two of eight general registers, takes a result from a separate combinational execute unit, and hands it to a result-dispatch stage. That stage can write a register, take the next word from an external parameter stream, move the outgoing method pointer, and emit a (method, data) send. The program is written in through a simple load port and its length is set by a static input.

A start pulse clears the machine, puts the first parameter word in register 1 and begins fetching at byte address 0. Every branch and every exit has a delay slot. A taken branch may annul its slot. An exit placed in a branch slot still runs the branch target once before stopping. The sequencer halts with an error flag on an invalid operation, on a branch inside a slot, or when the program counter leaves the loaded program.

The FSM has four states. IDLE waits after reset. RUN executes ordinary instructions. SLOT executes the single instruction after a branch or exit. DONE holds the result. The named transitions are:
- `start`: IDLE or DONE to RUN.
- `branch-slot`: RUN to SLOT, on a taken branch that does not annul.
- `annul`: RUN to RUN, with the counter loaded from the target.
- `exit-slot`: RUN to SLOT, on the exit flag.
- `slot-resume`: SLOT to RUN, applying the pending target.
- `slot-exit-chain`: SLOT to SLOT, when an exit sits in a branch slot.
- `finish`: SLOT to DONE.
- `fault`: RUN or SLOT to DONE, with `err` raised.

Top module: `macro_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `err`, `send_valid` and `param_take` are all 0.
- R2: On a start pulse the block clears registers r2 to r7, the method pointer (address 0, step 0) and the program counter. It loads r1 with `start_param`, and `param_data` is then the second parameter.
- R3: Register r0 reads as zero. A write to r0 is discarded.
- R4: The instruction word is laid out as follows: operation in [2:0], result operation in [6:4], exit flag in bit 7, destination in [10:8], source A in [13:11], source B in [16:14], and a signed 18-bit immediate in [31:14]. The ALU selector sits in [21:17]: 0 add, 2 subtract, 8 xor, 9 or, 10 and, 11 A and not B, 12 not (A and B). Operation 1 adds the immediate to A.
- R5: The bitfield operations use a source offset in [21:17], a size in [26:22] and a destination offset in [31:27], with mask = 2^size-1. Operation 2 inserts (B>>offset)&mask into A at the destination offset. Operation 3 gives ((B>>A)&mask)<<destination offset. Operation 4 gives ((B>>source offset)&mask)<<A.
- R6: Operation 5 drives `rd_addr` = A + immediate and uses `rd_data` as its result.
- R7: The result operations are:
  - 0: the destination takes the parameter.
  - 1: the destination takes the result.
  - 2: as 1, and the method pointer is set from the result (address [11:0], step [17:12]).
  - 3: the destination takes the parameter, and the result is sent.
  - 4: as 1, and the result is sent.
  - 5: the destination takes the parameter, and the pointer is set from the result.
  - 6: as 2, and the parameter is sent.
  - 7: as 2, and result[17:12] is sent.

  A send uses the current pointer and then advances the address by the step. Each parameter use pulses `param_take`.
- R8: Operation 7 is a branch. It tests source A for zero (bit 4 = 0) or nonzero (bit 4 = 1). Its target is its own byte address plus immediate×4. When it is taken and bit 5 is 0, exactly one following instruction runs before the target.
- R9: A taken branch with bit 5 set skips its slot. When the branch is not taken, the next instruction runs normally.
- R10: With the exit flag set, exactly one further instruction runs and then `done` rises and holds. After that there are no sends and no parameter takes until the next start.
- R11: An exit in a branch slot runs the branch target instruction once and then stops.
- R12: Operation 6, a branch in a slot, or a fetch at or beyond `prog_len` words makes the block stop with `err` and `done` both 1. The faulting instruction has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_we | input | 1 | Instruction memory write enable |
| load_addr | input | 6 | Instruction memory word address |
| load_data | input | 32 | Instruction word to write |
| prog_len | input | 7 | Program length in words |
| start | input | 1 | Start pulse, honoured in IDLE or DONE |
| start_param | input | 32 | First parameter word, loaded into r1 |
| param_take | output | 1 | Current parameter word consumed this cycle |
| param_data | input | 32 | Head of the parameter stream |
| rd_addr | output | 32 | External register read address |
| rd_data | input | 32 | External register read data |
| send_valid | output | 1 | A send is issued this cycle |
| send_method | output | 12 | Method address of the send |
| send_data | output | 32 | Data of the send |
| busy | output | 1 | RUN or SLOT state |
| done | output | 1 | DONE state |
| err | output | 1 | Last run ended on a fault |

## Verification
A wrong program counter, or a lost pending target, shows up as an extra, missing or reordered send. The send sequence is compared item by item, so the first wrong send gives the cycle of the fault. A wrong register value or a wrong method pointer appears in the data or method field of the next send that uses it. A wrong FSM exit shows as `done` or `err` taking the wrong value at the end of the run, as sends that continue after `done`, or as a mismatch in the count of parameter takes.

// File: rtl/macro_seq_pkg.sv
package macro_seq_pkg;

    localparam int WORD_W = 32;
    localparam int NUM_REGS = 8;

    typedef enum logic [2:0] {
        OP_ALU  = 3'd0,
        OP_ADDI = 3'd1,
        OP_XINS = 3'd2,
        OP_XSHI = 3'd3,
        OP_XSHR = 3'd4,
        OP_READ = 3'd5,
        OP_BAD  = 3'd6,
        OP_BRA  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        RO_FETCH       = 3'd0,
        RO_MOVE        = 3'd1,
        RO_MOVE_PTR    = 3'd2,
        RO_FETCH_SEND  = 3'd3,
        RO_MOVE_SEND   = 3'd4,
        RO_FETCH_PTR   = 3'd5,
        RO_PTR_SENDPRM = 3'd6,
        RO_PTR_SENDSTP = 3'd7
    } rop_e;

    // imm[2:0] = source B, imm[7:3] = ALU selector / bit offset,
    // imm[12:8] = field size, imm[17:13] = destination offset
    typedef struct packed {
        logic [17:0] imm;
        logic [2:0]  ra;
        logic [2:0]  rd;
        logic        ex;
        rop_e        rop;
        logic        pad;
        op_e         op;
    } insn_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_SLOT = 2'd2,
        S_DONE = 2'd3
    } state_e;

endpackage

// File: rtl/macro_exec.sv
module macro_exec
    import macro_seq_pkg::*;
(
    input  insn_t              insn,
    input  logic [WORD_W-1:0]  opa,
    input  logic [WORD_W-1:0]  opb,
    input  logic [WORD_W-1:0]  rd_data,
    output logic [WORD_W-1:0]  result,
    output logic [WORD_W-1:0]  ext_addr
);
    logic [WORD_W-1:0] simm;
    logic [4:0]        src_off, fsize, dst_off;
    logic [WORD_W-1:0] mask, field;

    always_comb begin
        simm     = {{(WORD_W-18){insn.imm[17]}}, insn.imm};
        src_off  = insn.imm[7:3];
        fsize    = insn.imm[12:8];
        dst_off  = insn.imm[17:13];
        mask     = (WORD_W'(1) << fsize) - WORD_W'(1);
        field    = (opb >> src_off) & mask;
        ext_addr = opa + simm;
        unique case (insn.op)
            OP_ALU: begin
                unique case (insn.imm[7:3])
                    5'd0:    result = opa + opb;
                    5'd2:    result = opa - opb;
                    5'd8:    result = opa ^ opb;
                    5'd9:    result = opa | opb;
                    5'd10:   result = opa & opb;
                    5'd11:   result = opa & ~opb;
                    5'd12:   result = ~(opa & opb);
                    default: result = '0;
                endcase
            end
            OP_ADDI: result = opa + simm;
            OP_XINS: result = (opa & ~(mask << dst_off)) | (field << dst_off);
            OP_XSHI: result = ((opb >> opa) & mask) << dst_off;
            OP_XSHR: result = field << opa;
            OP_READ: result = rd_data;
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/macro_regfile.sv
module macro_regfile #(
    parameter int NREG = 8,
    parameter int W    = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [W-1:0]            init_val,
    input  logic                    we,
    input  logic [$clog2(NREG)-1:0] waddr,
    input  logic [W-1:0]            wdata,
    input  logic [$clog2(NREG)-1:0] raddr_a,
    input  logic [$clog2(NREG)-1:0] raddr_b,
    output logic [W-1:0]            rdata_a,
    output logic [W-1:0]            rdata_b
);
    logic [W-1:0] regs [1:NREG-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 1; i < NREG; i++) regs[i] <= '0;
        end else if (clr) begin
            for (int i = 1; i < NREG; i++) regs[i] <= (i == 1) ? init_val : '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/macro_seq.sv
module macro_seq
    import macro_seq_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    localparam int IA_W  = $clog2(IMEM_DEPTH),
    localparam int PC_W  = IA_W + 2,
    localparam int LEN_W = IA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_we,
    input  logic [IA_W-1:0]   load_addr,
    input  logic [31:0]       load_data,
    input  logic [LEN_W-1:0]  prog_len,
    input  logic              start,
    input  logic [31:0]       start_param,
    output logic              param_take,
    input  logic [31:0]       param_data,
    output logic [31:0]       rd_addr,
    input  logic [31:0]       rd_data,
    output logic              send_valid,
    output logic [11:0]       send_method,
    output logic [31:0]       send_data,
    output logic              busy,
    output logic              done,
    output logic              err
);
    logic [31:0] imem [IMEM_DEPTH];

    state_e           state, state_n;
    logic [PC_W-1:0]  pc, pc_n, pend_pc, pend_pc_n;
    logic             pend_v, pend_v_n, exit_pend, exit_pend_n, err_q, err_n;
    logic [11:0]      ptr_addr, ptr_addr_n;
    logic [5:0]       ptr_step, ptr_step_n;

    insn_t            insn;
    logic [31:0]      opa, opb, result, off32;
    logic             exec_on, in_range, fault, go, is_bra, taken, fetch_rop, set_ptr, launch;
    logic [PC_W-1:0]  br_tgt, pc_inc;
    logic [11:0]      cur_addr;
    logic [5:0]       cur_step;

    always_ff @(posedge clk) begin
        if (load_we) imem[load_addr] <= load_data;
    end

    assign insn = insn_t'(imem[pc[PC_W-1:2]]);

    macro_regfile #(.NREG(NUM_REGS), .W(WORD_W)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .clr(start && (state == S_IDLE || state == S_DONE)),
        .init_val(start_param),
        .we(go && !is_bra), .waddr(insn.rd),
        .wdata(fetch_rop ? param_data : result),
        .raddr_a(insn.ra), .raddr_b(insn.imm[2:0]),
        .rdata_a(opa), .rdata_b(opb)
    );

    macro_exec u_exec (
        .insn(insn), .opa(opa), .opb(opb), .rd_data(rd_data),
        .result(result), .ext_addr(rd_addr)
    );

    // Decode and result dispatch
    always_comb begin
        exec_on   = (state == S_RUN) || (state == S_SLOT);
        in_range  = {1'b0, pc[PC_W-1:2]} < prog_len;
        is_bra    = insn.op == OP_BRA;
        fault     = exec_on && (!in_range || insn.op == OP_BAD || (state == S_SLOT && is_bra));
        go        = exec_on && !fault;
        taken     = is_bra && (insn.rop[0] ? (opa != '0) : (opa == '0));
        off32     = {{12{insn.imm[17]}}, insn.imm, 2'b00};
        br_tgt    = pc + off32[PC_W-1:0];
        pc_inc    = pc + PC_W'(4);
        fetch_rop = insn.rop inside {RO_FETCH, RO_FETCH_SEND, RO_FETCH_PTR};
        set_ptr   = go && !is_bra &&
                    (insn.rop inside {RO_MOVE_PTR, RO_FETCH_PTR, RO_PTR_SENDPRM, RO_PTR_SENDSTP});
        launch    = go && !is_bra &&
                    (insn.rop inside {RO_FETCH_SEND, RO_MOVE_SEND, RO_PTR_SENDPRM, RO_PTR_SENDSTP});
        param_take = go && !is_bra &&
                    (insn.rop inside {RO_FETCH, RO_FETCH_SEND, RO_FETCH_PTR, RO_PTR_SENDPRM});
        cur_addr  = set_ptr ? result[11:0]  : ptr_addr;
        cur_step  = set_ptr ? result[17:12] : ptr_step;
        send_valid  = launch;
        send_method = cur_addr;
        unique case (insn.rop)
            RO_PTR_SENDPRM: send_data = param_data;
            RO_PTR_SENDSTP: send_data = {26'd0, result[17:12]};
            default:        send_data = result;
        endcase
        ptr_addr_n = launch ? cur_addr + {6'd0, cur_step} : cur_addr;
        ptr_step_n = cur_step;
    end

    // Next-state logic
    always_comb begin
        state_n     = state;
        pc_n        = pc;
        pend_pc_n   = pend_pc;
        pend_v_n    = pend_v;
        exit_pend_n = exit_pend;
        err_n       = err_q;
        unique case (state)
            S_IDLE, S_DONE: begin
                if (start) begin
                    state_n = S_RUN; pc_n = '0; pend_v_n = 1'b0;
                    exit_pend_n = 1'b0; err_n = 1'b0;
                end
            end
            S_RUN: begin
                if (fault) begin
                    state_n = S_DONE; err_n = 1'b1;
                end else if (taken) begin
                    if (insn.rop[1]) begin
                        pc_n = br_tgt;
                    end else begin
                        pc_n = pc_inc; pend_pc_n = br_tgt; pend_v_n = 1'b1; state_n = S_SLOT;
                    end
                end else begin
                    pc_n = pc_inc;
                    if (insn.ex) begin
                        state_n = S_SLOT; exit_pend_n = 1'b1;
                    end
                end
            end
            S_SLOT: begin
                if (fault) begin
                    state_n = S_DONE; err_n = 1'b1;
                end else if (exit_pend) begin
                    state_n = S_DONE;
                end else begin
                    pc_n = pend_v ? pend_pc : pc_inc;
                    pend_v_n = 1'b0;
                    if (insn.ex) exit_pend_n = 1'b1;
                    else         state_n = S_RUN;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE; pc <= '0; pend_pc <= '0; pend_v <= 1'b0;
            exit_pend <= 1'b0; err_q <= 1'b0; ptr_addr <= '0; ptr_step <= '0;
        end else begin
            state <= state_n; pc <= pc_n; pend_pc <= pend_pc_n; pend_v <= pend_v_n;
            exit_pend <= exit_pend_n; err_q <= err_n;
            if (start && (state == S_IDLE || state == S_DONE)) begin
                ptr_addr <= '0; ptr_step <= '0;
            end else if (go) begin
                ptr_addr <= ptr_addr_n; ptr_step <= ptr_step_n;
            end
        end
    end

    // Outputs
    always_comb begin
        busy = (state == S_RUN) || (state == S_SLOT);
        done = (state == S_DONE);
        err  = err_q;
    end
endmodule

// File: rtl/macro_seq_chk.sv
module macro_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic err,
    input logic send_valid,
    input logic param_take
);
    assert_send_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        send_valid |-> busy);
    assert_take_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        param_take |-> busy);
    assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    assert_err_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!send_valid && !param_take));
    assert_done_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

bind macro_seq macro_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .err(err), .send_valid(send_valid), .param_take(param_take)
);

// File: tb/macro_seq_tb.sv
module macro_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_we = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [6:0]  prog_len = '0;
    logic        start = 1'b0;
    logic [31:0] start_param = '0;
    logic        param_take;
    logic [31:0] param_data;
    logic [31:0] rd_addr, rd_data;
    logic        send_valid;
    logic [11:0] send_method;
    logic [31:0] send_data;
    logic        busy, done, err;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [31:0] plist [64];
    int          pidx = 0;
    logic [31:0] prog [$];
    logic [43:0] exp_q [$];
    int          exp_r [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign param_data = plist[pidx];
    assign rd_data    = rd_addr ^ 32'hA5A5_0000;

    always @(posedge clk) if (param_take) pidx <= pidx + 1;

    macro_seq dut_i (
        .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
        .load_data(load_data), .prog_len(prog_len), .start(start),
        .start_param(start_param), .param_take(param_take), .param_data(param_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .send_valid(send_valid),
        .send_method(send_method), .send_data(send_data), .busy(busy),
        .done(done), .err(err)
    );

    function automatic logic [31:0] mk(int op, int rop, bit ex, int rd, int ra, int imm);
        logic [31:0] w;
        w = {imm[17:0], ra[2:0], rd[2:0], ex, rop[2:0], 1'b0, op[2:0]};
        return w;
    endfunction
    function automatic int alu(int sel, int rb);
        return (sel << 3) | rb;
    endfunction
    function automatic int bf(int doff, int sz, int soff, int rb);
        return (doff << 13) | (sz << 8) | (soff << 3) | rb;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic expect_send(int r, logic [11:0] m, logic [31:0] d);
        exp_q.push_back({m, d});
        exp_r.push_back(r);
    endtask

    // Monitor: compare each send against the scoreboard
    always @(negedge clk) begin
        if (rst_n && send_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected send actual=%0h/%0h expected=none",
                         send_method, send_data);
            end else begin
                logic [43:0] e;
                int r;
                e = exp_q.pop_front();
                r = exp_r.pop_front();
                if (e != {send_method, send_data}) begin
                    fails++;
                    $display("FAIL R%0d send actual=%0h/%0h expected=%0h/%0h",
                             r, send_method, send_data, e[43:32], e[31:0]);
                end
            end
        end
    end

    task automatic run_prog(input int len, input logic [31:0] p0, input bit exp_err,
                            input int exp_takes, input string tag);
        int base;
        int cyc;
        for (int i = 0; i < prog.size(); i++) begin
            @(negedge clk);
            load_we = 1'b1; load_addr = 6'(i); load_data = prog[i];
        end
        @(negedge clk);
        load_we = 1'b0;
        prog_len = 7'(len);
        start_param = p0;
        base = pidx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 500) begin
            @(negedge clk);
            cyc++;
        end
        check(done == 1'b1, {tag, " done"}, 64'(done), 64'd1);
        check(err == exp_err, {tag, " err"}, 64'(err), 64'(exp_err));
        check(exp_q.size() == 0, {tag, " all sends seen"}, 64'(exp_q.size()), 64'd0);
        check(pidx - base == exp_takes, {tag, " param takes"}, 64'(pidx - base), 64'(exp_takes));
        repeat (3) @(negedge clk);
        check(done == 1'b1, {tag, " done holds"}, 64'(done), 64'd1);
        exp_q.delete();
        exp_r.delete();
        prog.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) plist[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !err, "R1 idle after reset", {busy, done, err}, 3'b000);
        check(!send_valid && !param_take, "R1 no side effects", {send_valid, param_take}, 2'b00);

        // Program A: method pointer clear at start (R2), ALU ops (R4), r0 (R3), exit slot (R10)
        plist[pidx] = 32'h1234_5678;
        prog.push_back(mk(0,4,0,0,1,alu(0,0)));   expect_send(2, 12'h000, 32'h100);
        prog.push_back(mk(1,2,0,2,0,32'h1010));
        prog.push_back(mk(0,4,0,3,1,alu(0,1)));   expect_send(4, 12'h010, 32'h200);
        prog.push_back(mk(1,4,0,0,1,-5));         expect_send(4, 12'h011, 32'hFB);
        prog.push_back(mk(0,3,0,5,3,alu(8,1)));   expect_send(7, 12'h012, 32'h300);
        prog.push_back(mk(0,4,0,0,3,alu(2,1)));   expect_send(4, 12'h013, 32'h100);
        prog.push_back(mk(0,4,0,0,3,alu(11,1)));  expect_send(4, 12'h014, 32'h200);
        prog.push_back(mk(0,4,0,0,3,alu(9,1)));   expect_send(4, 12'h015, 32'h300);
        prog.push_back(mk(0,4,0,0,3,alu(10,1)));  expect_send(4, 12'h016, 32'h0);
        prog.push_back(mk(0,4,1,0,5,alu(0,0)));   expect_send(3, 12'h017, 32'h1234_5678); // R3: r0 write dropped
        prog.push_back(mk(0,4,0,6,1,alu(12,3)));  expect_send(10, 12'h018, 32'hFFFF_FFFF); // R10 slot
        prog.push_back(mk(1,4,0,0,0,999));
        run_prog(12, 32'h100, 1'b0, 1, "R10 progA");

        // Program B: loop with delay slot (R8), then annulled variant (R9)
        for (int v = 0; v < 2; v++) begin
            prog.push_back(mk(1,2,0,2,0,32'h1020));
            prog.push_back(mk(1,4,0,1,1,-1));
            prog.push_back(mk(7,1 | (v << 1),0,0,1,-1));
            prog.push_back(mk(1,1,0,3,3,1));
            prog.push_back(mk(0,4,1,0,3,alu(0,0)));
            prog.push_back(mk(1,1,0,0,0,0));
            expect_send(8, 12'h020, 32'd2);
            expect_send(8, 12'h021, 32'd1);
            expect_send(8, 12'h022, 32'd0);
            if (v == 0) expect_send(8, 12'h023, 32'd3);   // R8 slot ran each pass
            else        expect_send(9, 12'h023, 32'd1);   // R9 slot only on fall-through
            run_prog(6, 32'd3, 1'b0, 0, v == 0 ? "R8 loop" : "R9 annul");
        end

        // Program C: exit in branch slot runs target (R11), branch-if-zero (R8)
        prog.push_back(mk(1,2,0,2,0,32'h1030));
        prog.push_back(mk(7,0,0,0,0,3));
        prog.push_back(mk(1,4,1,0,0,7));          expect_send(11, 12'h030, 32'd7);
        prog.push_back(mk(1,4,0,0,0,32'h33));
        prog.push_back(mk(1,4,0,0,0,9));          expect_send(11, 12'h031, 32'd9);
        prog.push_back(mk(1,4,0,0,0,32'h55));
        run_prog(6, 32'd0, 1'b0, 0, "R11 exit in slot");

        // Program D: bitfields (R5), read (R6), result operations (R7)
        plist[pidx]   = 32'h1111_1111;
        plist[pidx+1] = 32'h22;
        plist[pidx+2] = 32'h33;
        prog.push_back(mk(1,2,0,2,0,32'h1040));
        prog.push_back(mk(1,1,0,4,0,4));
        prog.push_back(mk(2,4,0,3,1,bf(16,8,4,1))); expect_send(5, 12'h040, 32'h00BC_ABCD);
        prog.push_back(mk(3,4,0,0,4,bf(8,4,0,1)));  expect_send(5, 12'h041, 32'hC00);
        prog.push_back(mk(4,4,0,0,4,bf(0,8,8,1)));  expect_send(5, 12'h042, 32'hAB0);
        prog.push_back(mk(5,4,0,0,4,32'h100));      expect_send(6, 12'h043, 32'hA5A5_0104);
        prog.push_back(mk(1,6,0,5,0,32'h1050));     expect_send(7, 12'h050, 32'h1111_1111);
        prog.push_back(mk(1,7,0,6,0,32'h2060));     expect_send(7, 12'h060, 32'd2);
        prog.push_back(mk(1,0,0,7,0,0));
        prog.push_back(mk(1,5,0,3,0,32'h1070));
        prog.push_back(mk(0,4,1,0,7,alu(0,3)));     expect_send(7, 12'h070, 32'h55);
        prog.push_back(mk(1,1,0,0,0,0));
        run_prog(12, 32'h0000_ABCD, 1'b0, 3, "R7 dispatch");

        // R12 faults: invalid op, branch in slot, running past the program
        prog.push_back(mk(1,4,0,0,0,1));            expect_send(12, 12'h000, 32'd1);
        prog.push_back(32'h0000_0006);
        prog.push_back(mk(1,4,0,0,0,2));
        run_prog(3, 32'd0, 1'b1, 0, "R12 bad op");

        prog.push_back(mk(7,0,0,0,0,2));
        prog.push_back(mk(7,0,0,0,0,0));
        prog.push_back(mk(1,4,1,0,0,3));
        run_prog(3, 32'd0, 1'b1, 0, "R12 branch in slot");

        prog.push_back(mk(1,4,0,0,0,5));            expect_send(12, 12'h000, 32'd5);
        prog.push_back(mk(1,4,0,0,0,6));            expect_send(12, 12'h000, 32'd6);
        run_prog(2, 32'd0, 1'b1, 0, "R12 past end");

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule